// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a serial command decoder in a nonvolatile memory device. It stages the data bytes of a page-write command and commits them to the memory array as one page after a programming delay that it times itself. The decoder tells it when a write command starts and gives it the target address. It then delivers each received data byte with a strobe, reports the rise of chip select, and states whether that rise came exactly between two bytes. Protection logic supplies a single flag that says whether the page may be written. A second flag reports whether the write-enable latch is set.

The page is 128 bytes. Only the low seven address bits advance from byte to byte, so a long burst wraps inside its page, and a later byte replaces an earlier byte at the same location. A commit runs only when every condition holds at the chip-select rise. While the commit runs, `busy` stays high for exactly `PROG_CYCLES` clock cycles. During the first 128 of those cycles, the block walks the page one offset per cycle and writes only the offsets that received data. When `busy` falls, it pulses `wel_clr` once so that the write-enable latch is cleared.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy`, `mem_we` and `wel_clr` are all 0.
- R2: Each accepted data byte advances only the low 7 bits of the page offset, wrapping 127 to 0. Every commit write has `mem_addr[ADDR_W-1:7]` equal to the upper bits of `start_addr`.
- R3: When more than 128 bytes arrive, the later byte at a repeated offset replaces the earlier one. The commit writes only the last value.
- R4: A commit starts only when `cs_rise` is sampled together with `at_boundary`=1. A rise with `at_boundary`=0 abandons the command, with no `busy` and no memory write.
- R5: If `wel_set`=0 at the chip-select rise, the command is dropped: no `busy`, no write and no `wel_clr`.
- R6: If `wr_permit`=0 at the chip-select rise, the command is dropped: no `busy` and no write.
- R7: `busy` is 1 from the cycle after a qualifying chip-select rise and stays 1 for exactly `PROG_CYCLES` cycles.
- R8: `wel_clr` is a one-cycle pulse in the first cycle after `busy` falls, and it occurs only then.
- R9: During a commit, each offset that received a byte is written exactly once, in busy cycle number equal to its offset (counting from 0). Offsets that received no byte are not written and keep their old contents.
- R10: While `busy` is 1, `start`, `byte_vld` and `cs_rise` are ignored. They neither extend `busy`, nor change the staged page, nor start a second commit.
- R11: A chip-select rise before any data byte has arrived abandons the command, even when every other condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse: a page-write command was decoded |
| start_addr | input | ADDR_W | Byte address given with the command |
| byte_vld | input | 1 | One-cycle strobe: a data byte is complete |
| byte_data | input | 8 | Data byte that comes with `byte_vld` |
| cs_rise | input | 1 | One-cycle pulse: chip select went inactive |
| at_boundary | input | 1 | The chip-select rise fell right after a whole byte |
| wel_set | input | 1 | Write-enable latch state |
| wr_permit | input | 1 | Protection logic allows the whole page |
| busy | output | 1 | Self-timed programming in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | 8 | Memory write data |
| wel_clr | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
The assertions assume the decoder gives single-cycle pulses on `start`, `byte_vld` and `cs_rise`. They also assume `byte_vld` never comes in the same cycle as `cs_rise`, and that a command's bytes come only between its `start` and its chip-select rise. The bench keeps to this by raising at most one of these strobes per cycle, always for one cycle, with an idle cycle between bytes. The one exception is the test that deliberately sends strobes while `busy` is high. The bench keeps its own copy of the memory, updated only from the write port, and compares it with an expectation built from the byte stream.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_FILL = 2'd1,
    PW_PROG = 2'd2
  } pw_state_e;

  // next in-page offset: low bits only, wrapping at the page size
  function automatic int unsigned pw_next_off(int unsigned off, int unsigned page);
    return (off + 1) % page;
  endfunction

  // commit may start only if every condition holds at the chip-select rise
  function automatic logic pw_commit_ok(logic bnd, logic wel, logic perm, logic got);
    return bnd & wel & perm & got;
  endfunction

endpackage

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 128,
  parameter int OFF_W      = $clog2(PAGE_BYTES),
  parameter int BASE_W     = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [OFF_W-1:0]  rd_idx,
  input  logic              busy,
  output logic [7:0]        rd_data,
  output logic              rd_vld,
  output logic [BASE_W-1:0] base_o,
  output logic              got_byte
);
  import pwb_pkg::*;

  logic [7:0]            page_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [OFF_W-1:0]      off_q;
  logic [BASE_W-1:0]     base_q;

  always_ff @(posedge clk) begin
    if (wr_en) page_q[off_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      off_q  <= '0;
      base_q <= '0;
    end else if (fill_start) begin
      mask_q <= '0;
      off_q  <= start_addr[OFF_W-1:0];
      base_q <= start_addr[ADDR_W-1:OFF_W];
    end else if (wr_en) begin
      mask_q[off_q] <= 1'b1;
      off_q         <= OFF_W'(pw_next_off(32'(off_q), PAGE_BYTES));
    end
  end

  assign rd_data  = page_q[rd_idx];
  assign rd_vld   = mask_q[rd_idx];
  assign base_o   = base_q;
  assign got_byte = |mask_q;

  // R10
  mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mask_q) && $stable(base_q)));

endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int PROG_CYCLES = 1000,
  parameter int PAGE_BYTES  = 128,
  parameter int OFF_W       = $clog2(PAGE_BYTES),
  parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  output logic             run,
  output logic             done,
  output logic             scan_on,
  output logic [OFF_W-1:0] scan_idx
);
  localparam int SC_W = OFF_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SC_W-1:0]  scan_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      scan_q <= '0;
    end else if (load) begin
      run_q  <= 1'b1;
      cnt_q  <= CNT_W'(PROG_CYCLES - 1);
      scan_q <= '0;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
      if (scan_on)     scan_q <= scan_q + 1'b1;
    end
  end

  assign run      = run_q;
  assign done     = run_q && (cnt_q == '0);
  assign scan_on  = run_q && (scan_q < SC_W'(PAGE_BYTES));
  assign scan_idx = scan_q[OFF_W-1:0];

endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cs_rise,
  input  logic at_boundary,
  input  logic wel_set,
  input  logic wr_permit,
  input  logic got_byte,
  input  logic busy,
  input  logic done,
  output logic fill_start,
  output logic fill_on,
  output logic load,
  output logic wel_clr
);
  import pwb_pkg::*;

  pw_state_e state_q;
  logic      clr_q;
  logic      qual;

  assign qual       = pw_commit_ok(at_boundary, wel_set, wr_permit, got_byte);
  assign fill_start = (state_q == PW_IDLE) && start;
  assign fill_on    = (state_q == PW_FILL);
  assign load       = fill_on && cs_rise && qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      unique case (state_q)
        PW_IDLE: if (start) state_q <= PW_FILL;
        PW_FILL: if (cs_rise) state_q <= qual ? PW_PROG : PW_IDLE;
        PW_PROG: if (done) begin
          state_q <= PW_IDLE;
          clr_q   <= 1'b1;
        end
        default: state_q <= PW_IDLE;
      endcase
    end
  end

  assign wel_clr = clr_q;

  // R4 R5 R6 R11
  rise_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && at_boundary && wel_set && wr_permit && got_byte));

  // R8
  welclr_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> $fell(busy));

  // R8
  busy_end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wel_clr);

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W      = 17,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              at_boundary,
  input  logic              wel_set,
  input  logic              wr_permit,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  output logic              wel_clr
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  logic              fill_start, fill_on, load, done, run, scan_on, got_byte, rd_vld;
  logic [OFF_W-1:0]  scan_idx;
  logic [7:0]        rd_data;
  logic [BASE_W-1:0] base;
  logic              wr_en;

  assign wr_en = fill_on && byte_vld;

  pwb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_rise(cs_rise),
    .at_boundary(at_boundary), .wel_set(wel_set), .wr_permit(wr_permit),
    .got_byte(got_byte), .busy(run), .done(done), .fill_start(fill_start),
    .fill_on(fill_on), .load(load), .wel_clr(wel_clr)
  );

  pwb_buffer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .start_addr(start_addr),
    .wr_en(wr_en), .wr_data(byte_data), .rd_idx(scan_idx), .busy(run),
    .rd_data(rd_data), .rd_vld(rd_vld), .base_o(base), .got_byte(got_byte)
  );

  pwb_timer #(.PROG_CYCLES(PROG_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run), .done(done),
    .scan_on(scan_on), .scan_idx(scan_idx)
  );

  assign busy     = run;
  assign mem_we   = scan_on && rd_vld;
  assign mem_addr = {base, scan_idx};
  assign mem_data = rd_data;

  // busy-length observer for the R7 check
  logic [CNT_W:0] blen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen_q <= '0;
    else if (busy) blen_q <= blen_q + 1'b1;
    else           blen_q <= '0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen_q == (CNT_W+1)'(PROG_CYCLES)));

  // R9
  mem_we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!busy && !mem_we && !wel_clr));

endmodule

// File: tb/sim_page_write_buffer.sv
module sim_page_write_buffer;
  localparam int AW   = 9;
  localparam int PAGE = 128;
  localparam int PROG = 200;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, byte_vld = 1'b0, cs_rise = 1'b0;
  logic at_boundary = 1'b0, wel_set = 1'b0, wr_permit = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic busy, mem_we, wel_clr;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;

  always #5 clk = ~clk;

  page_write_buffer #(.ADDR_W(AW), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .at_boundary(at_boundary), .wel_set(wel_set), .wr_permit(wr_permit),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .wel_clr(wel_clr)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] bmem [MEMN];  // filled only from the write port
  logic [7:0] emem [MEMN];  // expectation

  always @(negedge clk) if (mem_we) bmem[mem_addr] = mem_data;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [8:0] addr;
    logic [8:0] n;
    logic       bnd;
    logic       wel;
    logic       perm;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{9'h000, 9'd128, 1'b1, 1'b1, 1'b1, 8'h10}, // R7 R8 full page
    '{9'h085, 9'd10,  1'b1, 1'b1, 1'b1, 8'h40}, // R9 partial, rest untouched
    '{9'h17E, 9'd6,   1'b1, 1'b1, 1'b1, 8'h70}, // R2 offset wraps 127->0
    '{9'h1F0, 9'd140, 1'b1, 1'b1, 1'b1, 8'hA0}, // R3 overwrite beyond 128
    '{9'h100, 9'd5,   1'b0, 1'b1, 1'b1, 8'h33}, // R4 rise off boundary
    '{9'h100, 9'd5,   1'b1, 1'b0, 1'b1, 8'h44}, // R5 latch not set
    '{9'h100, 9'd5,   1'b1, 1'b1, 1'b0, 8'h55}, // R6 page protected
    '{9'h0C0, 9'd0,   1'b1, 1'b1, 1'b1, 8'h66}  // R11 no data byte
  };

  function automatic int mismatches();
    int m = 0;
    for (int a = 0; a < MEMN; a++) if (bmem[a] !== emem[a]) m++;
    return m;
  endfunction

  task automatic txn(input string tag, input int addr, input int n, input bit bnd,
                     input bit wel, input bit perm, input int seed, input bit intr);
    bit commit;
    int bcnt, wcnt, wat;
    commit = bnd && wel && perm && (n != 0);
    @(negedge clk);
    start = 1'b1; start_addr = AW'(addr);
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < n; j++) begin
      byte_vld = 1'b1; byte_data = 8'(seed + 3 * j);
      @(negedge clk);
      byte_vld = 1'b0;
      @(negedge clk);
    end
    at_boundary = bnd; wel_set = wel; wr_permit = perm; cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
    if (commit)
      for (int j = 0; j < n; j++)
        emem[(addr & ~(PAGE - 1)) | ((addr + j) & (PAGE - 1))] = 8'(seed + 3 * j);
    check({tag, " busy after cs rise"}, int'(busy), int'(commit));
    bcnt = 0; wcnt = 0; wat = -1;
    for (int i = 0; i < PROG + 20; i++) begin
      if (busy) bcnt++;
      if (wel_clr) begin wcnt++; wat = i; end
      if (intr) begin  // R10 strobes during busy
        if (i == 5) begin start = 1'b1; start_addr = '0; end
        if (i == 6) begin start = 1'b0; byte_vld = 1'b1; byte_data = 8'hEE; end
        if (i == 7) byte_vld = 1'b0;
        if (i == 8) begin cs_rise = 1'b1; at_boundary = 1'b1; end
        if (i == 9) cs_rise = 1'b0;
      end
      @(negedge clk);
    end
    check({tag, " busy cycles"}, bcnt, commit ? PROG : 0);
    check({tag, " wel_clr pulses"}, wcnt, commit ? 1 : 0);
    if (commit) check({tag, " wel_clr position"}, wat, PROG);
    check({tag, " memory mismatches"}, mismatches(), 0);
  endtask

  initial begin
    for (int a = 0; a < MEMN; a++) begin
      bmem[a] = 8'(a ^ 8'h5A);
      emem[a] = 8'(a ^ 8'h5A);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy in reset", int'(busy), 0);
    check("R1 mem_we in reset", int'(mem_we), 0);
    check("R1 wel_clr in reset", int'(wel_clr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);

    for (int v = 0; v < 8; v++)
      txn($sformatf("vec%0d", v), int'(VECS[v].addr), int'(VECS[v].n),
          VECS[v].bnd, VECS[v].wel, VECS[v].perm, int'(VECS[v].seed), 1'b0);

    // R10: strobes during busy are ignored
    txn("R10 intrusion", 9'h140, 3, 1'b1, 1'b1, 1'b1, 8'h21, 1'b1);
    // R2 page base held: wrap at top of last page stays in that page
    txn("R2 last page wrap", 9'h1FF, 2, 1'b1, 1'b1, 1'b1, 8'h90, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule